// File: doc/BRIEF.md
# Comparator-Driven Successive-Approximation Sequencer

This block lives on the host side of a serial link to a companion device. The device has no converter of its own. It has a 7-bit threshold DAC loaded over SPI and three comparators, each comparing one analog channel with that threshold. The sequencer turns this into an analog-to-digital conversion. It writes trial threshold codes in 8-bit frames, reads the comparator bits that return in the same exchanges, and builds a 7-bit code for the requested channel one bit at a time, starting from the most significant bit.

The device answers one frame late. The comparator bits shifted back during a frame describe the threshold set by the frame before it. The sequencer therefore follows every trial write with a second frame that repeats the same code and carries the verdict back. A short go/no-go mode writes one limit code, collects the verdict in the next frame, and reports pass or fail.

Software starts a job with a one-cycle `start`, watches `busy`, and takes the outputs on the single-cycle `done`. The outputs hold their values until the next job completes.

Top module: `cmp_sar_seq`

## Requirements
- R1: Each frame is 8 bits long with chip select low for the whole frame. The clock rests low and the device samples data on rising clock edges. Data goes out most significant bit first. Bit 7 is always 1 (a threshold write) and bits 6..0 carry the code.
- R2: The comparator bits are taken from the frame that follows the write they judge. Bit 7 belongs to channel 2, bit 6 to channel 1 and bit 5 to channel 0; bit 4 and bits 3..0 are ignored. A 1 means the channel lies above the threshold.
- R3: A full conversion (mode 0) tries bits 6 down to 0. Each trial sets the bit under test, and clears it again when the returned bit is 0. Each trial uses two frames, a write and a repeat of the same code, so a conversion takes 14 frames. The result is the largest code that the channel exceeds.
- R4: Code 0 is never written.
- R5: A full-conversion code below 20 is reported as 20 with `underrange` high. Otherwise `underrange` is low.
- R6: Go/no-go mode (mode 1) uses two frames carrying the limit code. `pass` reports the returned channel bit and `result` reports the limit that was used. A limit below 20 is raised to 20.
- R7: A channel select of 3 acts as channel 2.
- R8: A `start` pulse while `busy` is high has no effect.
- R9: `busy` rises the cycle after an accepted `start`. `done` is a single-cycle pulse in the cycle where `busy` has fallen. `result`, `pass` and `underrange` change only together with `done`.
- R10: After reset, `busy`, `done`, `result`, `pass` and `underrange` are 0, `cs_n` is 1 and `sclk` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | One-cycle request to begin a job |
| chan_sel | input | 2 | Channel to measure (3 maps to 2) |
| mode_gng | input | 1 | 0 = full conversion, 1 = go/no-go |
| limit | input | 7 | Limit code for go/no-go |
| busy | output | 1 | Job in progress |
| done | output | 1 | One-cycle completion pulse |
| result | output | 7 | Converted code, or the limit used |
| pass | output | 1 | Go/no-go verdict |
| underrange | output | 1 | Conversion was clamped to the minimum code |
| sclk | output | 1 | SPI clock |
| mosi | output | 1 | SPI data to the device |
| miso | input | 1 | SPI data from the device |
| cs_n | output | 1 | SPI chip select, active low |

## Verification
The device model in the bench answers one frame late. A sequencer that used the bits returned with the write itself would judge every trial against the previous threshold, and its codes would drift away from the expected values. Channel levels are placed just above the MSB boundary, at full scale, at exactly 20 and 21, and at zero. These catch kept-bit and cleared-bit mistakes, a wrong underrange edge, and a missing clamp. A go/no-go run with the limit one code on either side of the level exposes an inverted verdict. A select of 3 and a restart attempted mid-job catch channel-index overrun and a restarted sequence, which would show up as a frame count above 14.

// File: rtl/sar_seq_pkg.sv
package sar_seq_pkg;
  typedef enum logic [1:0] {
    FR_IDLE = 2'd0,
    FR_LOW  = 2'd1,
    FR_HIGH = 2'd2,
    FR_GAP  = 2'd3
  } frame_st_t;

  typedef enum logic [2:0] {
    SQ_IDLE    = 3'd0,
    SQ_WR_GO   = 3'd1,
    SQ_WR_WAIT = 3'd2,
    SQ_RD_GO   = 3'd3,
    SQ_RD_WAIT = 3'd4
  } seq_st_t;
endpackage

// File: rtl/sar_spi_frame.sv
module sar_spi_frame
  import sar_seq_pkg::*;
#(
  parameter int FRAME_W = 8,
  parameter int HALF    = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               go,
  input  logic [FRAME_W-1:0] tx,
  input  logic               miso,
  output logic               sclk,
  output logic               cs_n,
  output logic               mosi,
  output logic               done,
  output logic [FRAME_W-1:0] rx
);
  localparam int CW = (HALF > 1) ? $clog2(HALF) : 1;
  localparam int BW = (FRAME_W > 1) ? $clog2(FRAME_W) : 1;
  localparam logic [CW-1:0] DIV_END = CW'(HALF - 1);
  localparam logic [BW-1:0] BIT_END = BW'(FRAME_W - 1);

  frame_st_t          st_q, st_n;
  logic [CW-1:0]      div_q, div_n;
  logic [BW-1:0]      bit_q, bit_n;
  logic [FRAME_W-1:0] tx_q, tx_n, rx_q, rx_n;
  logic               sclk_q, sclk_n, cs_q, cs_n_d, done_q, done_n;
  logic               div_last;

  assign div_last = (div_q == DIV_END);

  always_comb begin
    st_n   = st_q;
    div_n  = div_q + CW'(1);
    bit_n  = bit_q;
    tx_n   = tx_q;
    rx_n   = rx_q;
    sclk_n = sclk_q;
    cs_n_d = cs_q;
    done_n = 1'b0;
    case (st_q)
      FR_IDLE: begin
        div_n = '0;
        if (go) begin
          tx_n   = tx;
          cs_n_d = 1'b0;
          bit_n  = '0;
          st_n   = FR_LOW;
        end
      end
      FR_LOW: if (div_last) begin
        div_n  = '0;
        sclk_n = 1'b1;
        rx_n   = {rx_q[FRAME_W-2:0], miso};
        st_n   = FR_HIGH;
      end
      FR_HIGH: if (div_last) begin
        div_n  = '0;
        sclk_n = 1'b0;
        if (bit_q == BIT_END) begin
          cs_n_d = 1'b1;
          st_n   = FR_GAP;
        end else begin
          bit_n = bit_q + BW'(1);
          tx_n  = {tx_q[FRAME_W-2:0], 1'b0};
          st_n  = FR_LOW;
        end
      end
      FR_GAP: if (div_last) begin
        div_n  = '0;
        done_n = 1'b1;
        st_n   = FR_IDLE;
      end
      default: st_n = FR_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= FR_IDLE;
      div_q  <= '0;
      bit_q  <= '0;
      tx_q   <= '0;
      rx_q   <= '0;
      sclk_q <= 1'b0;
      cs_q   <= 1'b1;
      done_q <= 1'b0;
    end else begin
      st_q   <= st_n;
      div_q  <= div_n;
      bit_q  <= bit_n;
      tx_q   <= tx_n;
      rx_q   <= rx_n;
      sclk_q <= sclk_n;
      cs_q   <= cs_n_d;
      done_q <= done_n;
    end
  end

  assign sclk = sclk_q;
  assign cs_n = cs_q;
  assign mosi = tx_q[FRAME_W-1];
  assign done = done_q;
  assign rx   = rx_q;
endmodule

// File: rtl/sar_result_fmt.sv
module sar_result_fmt #(
  parameter int DAC_W    = 7,
  parameter int MIN_CODE = 20
) (
  input  logic [DAC_W-1:0] raw,
  input  logic             gng,
  output logic [DAC_W-1:0] code,
  output logic             under
);
  localparam logic [DAC_W-1:0] FLOOR = DAC_W'(MIN_CODE);

  always_comb begin
    under = !gng && (raw < FLOOR);
    code  = under ? FLOOR : raw;
  end
endmodule

// File: rtl/sar_trial_ctrl.sv
module sar_trial_ctrl
  import sar_seq_pkg::*;
#(
  parameter int DAC_W    = 7,
  parameter int FRAME_W  = 8,
  parameter int NUM_CH   = 3,
  parameter int CH_LSB   = 5,
  parameter int MIN_CODE = 20
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start,
  input  logic [1:0]         chan_sel,
  input  logic               mode_gng,
  input  logic [DAC_W-1:0]   limit,
  input  logic               frm_done,
  input  logic [FRAME_W-1:0] frm_rx,
  output logic               frm_go,
  output logic [FRAME_W-1:0] frm_tx,
  output logic               busy,
  output logic               done,
  output logic [DAC_W-1:0]   result,
  output logic               pass,
  output logic               underrange
);
  localparam int IW  = (DAC_W > 1) ? $clog2(DAC_W) : 1;
  localparam int CHW = (NUM_CH > 1) ? $clog2(NUM_CH) : 1;
  localparam logic [IW-1:0]    TOP_IDX = IW'(DAC_W - 1);
  localparam logic [DAC_W-1:0] FLOOR   = DAC_W'(MIN_CODE);
  localparam logic [DAC_W-1:0] FIRST   = {1'b1, {(DAC_W-1){1'b0}}};

  seq_st_t          st_q, st_n;
  logic [DAC_W-1:0] trial_q, trial_n;
  logic [IW-1:0]    idx_q, idx_n, idx_m1;
  logic [CHW-1:0]   ch_q, ch_n;
  logic             gng_q, gng_n;
  logic [DAC_W-1:0] res_q, res_n;
  logic             pass_q, pass_n, und_q, und_n, done_q, done_n;
  logic [NUM_CH-1:0] cmp_vec;
  logic             sel_bit;
  logic [DAC_W-1:0] fin_raw, fmt_code;
  logic             fmt_under;
  logic [CHW-1:0]   ch_cap;
  logic [DAC_W-1:0] lim_c;

  for (genvar g = 0; g < NUM_CH; g++) begin : g_cmp
    assign cmp_vec[g] = frm_rx[CH_LSB + g];
  end

  assign sel_bit = cmp_vec[ch_q];
  assign idx_m1  = idx_q - IW'(1);
  assign ch_cap  = (32'(chan_sel) >= NUM_CH) ? CHW'(NUM_CH - 1) : CHW'(chan_sel);
  assign lim_c   = (limit < FLOOR) ? FLOOR : limit;

  always_comb begin
    fin_raw = trial_q;
    if (!gng_q && !sel_bit) fin_raw[idx_q] = 1'b0;
  end

  sar_result_fmt #(.DAC_W(DAC_W), .MIN_CODE(MIN_CODE)) u_fmt (
    .raw   (fin_raw),
    .gng   (gng_q),
    .code  (fmt_code),
    .under (fmt_under)
  );

  always_comb begin
    st_n    = st_q;
    trial_n = trial_q;
    idx_n   = idx_q;
    ch_n    = ch_q;
    gng_n   = gng_q;
    res_n   = res_q;
    pass_n  = pass_q;
    und_n   = und_q;
    done_n  = 1'b0;
    case (st_q)
      SQ_IDLE: if (start) begin
        ch_n    = ch_cap;
        gng_n   = mode_gng;
        trial_n = mode_gng ? lim_c : FIRST;
        idx_n   = TOP_IDX;
        st_n    = SQ_WR_GO;
      end
      SQ_WR_GO:   st_n = SQ_WR_WAIT;
      SQ_WR_WAIT: if (frm_done) st_n = SQ_RD_GO;
      SQ_RD_GO:   st_n = SQ_RD_WAIT;
      SQ_RD_WAIT: if (frm_done) begin
        if (gng_q || idx_q == '0) begin
          res_n  = fmt_code;
          und_n  = fmt_under;
          pass_n = gng_q && sel_bit;
          done_n = 1'b1;
          st_n   = SQ_IDLE;
        end else begin
          trial_n         = fin_raw;
          trial_n[idx_m1] = 1'b1;
          idx_n           = idx_m1;
          st_n            = SQ_WR_GO;
        end
      end
      default: st_n = SQ_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= SQ_IDLE;
      trial_q <= FIRST;
      idx_q   <= TOP_IDX;
      ch_q    <= '0;
      gng_q   <= 1'b0;
      res_q   <= '0;
      pass_q  <= 1'b0;
      und_q   <= 1'b0;
      done_q  <= 1'b0;
    end else begin
      st_q    <= st_n;
      trial_q <= trial_n;
      idx_q   <= idx_n;
      ch_q    <= ch_n;
      gng_q   <= gng_n;
      res_q   <= res_n;
      pass_q  <= pass_n;
      und_q   <= und_n;
      done_q  <= done_n;
    end
  end

  assign frm_go     = (st_q == SQ_WR_GO) || (st_q == SQ_RD_GO);
  assign frm_tx     = {1'b1, trial_q};
  assign busy       = (st_q != SQ_IDLE);
  assign done       = done_q;
  assign result     = res_q;
  assign pass       = pass_q;
  assign underrange = und_q;
endmodule

// File: rtl/cmp_sar_seq.sv
module cmp_sar_seq #(
  parameter int DAC_W    = 7,
  parameter int NUM_CH   = 3,
  parameter int CH_LSB   = 5,
  parameter int MIN_CODE = 20,
  parameter int HALF     = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [1:0]       chan_sel,
  input  logic             mode_gng,
  input  logic [DAC_W-1:0] limit,
  output logic             busy,
  output logic             done,
  output logic [DAC_W-1:0] result,
  output logic             pass,
  output logic             underrange,
  output logic             sclk,
  output logic             mosi,
  input  logic             miso,
  output logic             cs_n
);
  localparam int FRAME_W = DAC_W + 1;

  logic [1:0]         rst_sync;
  logic               rst_int_n;
  logic               frm_go, frm_done;
  logic [FRAME_W-1:0] frm_tx, frm_rx;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_int_n = rst_sync[1];

  sar_spi_frame #(.FRAME_W(FRAME_W), .HALF(HALF)) u_frame (
    .clk   (clk),
    .rst_n (rst_int_n),
    .go    (frm_go),
    .tx    (frm_tx),
    .miso  (miso),
    .sclk  (sclk),
    .cs_n  (cs_n),
    .mosi  (mosi),
    .done  (frm_done),
    .rx    (frm_rx)
  );

  sar_trial_ctrl #(
    .DAC_W(DAC_W), .FRAME_W(FRAME_W), .NUM_CH(NUM_CH),
    .CH_LSB(CH_LSB), .MIN_CODE(MIN_CODE)
  ) u_ctrl (
    .clk        (clk),
    .rst_n      (rst_int_n),
    .start      (start),
    .chan_sel   (chan_sel),
    .mode_gng   (mode_gng),
    .limit      (limit),
    .frm_done   (frm_done),
    .frm_rx     (frm_rx),
    .frm_go     (frm_go),
    .frm_tx     (frm_tx),
    .busy       (busy),
    .done       (done),
    .result     (result),
    .pass       (pass),
    .underrange (underrange)
  );
endmodule

// File: rtl/sar_seq_chk.sv
module sar_seq_chk #(
  parameter int DAC_W    = 7,
  parameter int MIN_CODE = 20
) (
  input logic             clk,
  input logic             rst_n,
  input logic             busy,
  input logic             done,
  input logic [DAC_W-1:0] result,
  input logic             underrange,
  input logic             sclk,
  input logic             cs_n,
  input logic             mosi
);
  AST_DONE_NOT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy); // R9
  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R9
  AST_RESULT_ONLY_ON_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(result) |-> done); // R9
  AST_IDLE_CS_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> cs_n); // R1
  AST_SCLK_REST_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n |-> !sclk); // R1
  AST_WRITE_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(cs_n) |-> mosi); // R1
  AST_RESULT_FLOOR: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (result >= DAC_W'(MIN_CODE))); // R5
  AST_UNDER_AT_FLOOR: assert property (@(posedge clk) disable iff (!rst_n)
    (done && underrange) |-> (result == DAC_W'(MIN_CODE))); // R5
endmodule

bind cmp_sar_seq sar_seq_chk #(.DAC_W(DAC_W), .MIN_CODE(MIN_CODE)) u_chk (
  .clk(clk), .rst_n(rst_n), .busy(busy), .done(done), .result(result),
  .underrange(underrange), .sclk(sclk), .cs_n(cs_n), .mosi(mosi)
);

// File: tb/cmp_sar_seq_bench.sv
`timescale 1ns/1ps
module cmp_sar_seq_bench;
  logic       clk, rst_n, start, mode_gng, miso;
  logic [1:0] chan_sel;
  logic [6:0] limit, result;
  logic       busy, done, pass, underrange, sclk, mosi, cs_n;

  int n_chk, n_fail;
  int lvl [3];
  int frames, bad_frames, dev_bits;
  logic [7:0] dev_out, dev_in, dev_resp;
  logic [6:0] dev_dac;

  cmp_sar_seq u_cmp_sar_seq (
    .clk(clk), .rst_n(rst_n), .start(start), .chan_sel(chan_sel),
    .mode_gng(mode_gng), .limit(limit), .busy(busy), .done(done),
    .result(result), .pass(pass), .underrange(underrange),
    .sclk(sclk), .mosi(mosi), .miso(miso), .cs_n(cs_n)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  // device model: threshold register and comparators, answering one frame late
  function automatic logic [7:0] dev_answer(logic [6:0] dac);
    logic [7:0] r;
    r = 8'h1A; // low-battery flag and filler bits set, must be ignored (R2)
    for (int i = 0; i < 3; i++)
      r[5+i] = (dac != 7'd0) && (lvl[i] > int'(dac));
    return r;
  endfunction

  assign miso = dev_out[7];
  always @(negedge cs_n) if (rst_n) begin dev_out = dev_resp; dev_bits = 0; end
  always @(negedge sclk) if (rst_n && !cs_n) dev_out = {dev_out[6:0], 1'b0};
  always @(posedge sclk) if (rst_n && !cs_n) begin dev_in = {dev_in[6:0], mosi}; dev_bits++; end
  always @(posedge cs_n) if (rst_n && dev_bits == 8) begin
    frames++;
    if (!dev_in[7] || dev_in[6:0] == 7'd0) bad_frames++;
    else dev_dac = dev_in[6:0];
    dev_resp = dev_answer(dev_dac);
    dev_bits = 0;
  end

  task automatic check(string req, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wait_done(output bit ok);
    int n;
    ok = 0;
    for (n = 0; n < 5000; n++) begin
      @(negedge clk);
      if (done) begin ok = 1; break; end
    end
    if (!ok) begin n_chk++; n_fail++; $display("FAIL R9 actual=timeout expected=done"); end
  endtask

  task automatic launch(int ch, bit gng, int lim);
    @(negedge clk);
    chan_sel = 2'(ch); mode_gng = gng; limit = 7'(lim); start = 1'b1;
    frames = 0; bad_frames = 0;
    @(negedge clk);
    start = 1'b0;
    check("R9 busy after start", int'(busy), 1);
  endtask

  function automatic int exp_raw(int lv);
    int c;
    c = (lv < 1) ? 0 : lv - 1;
    if (c > 127) c = 127;
    return c;
  endfunction

  task automatic t_full(string req, int ch, int src);
    bit ok;
    int raw;
    raw = exp_raw(lvl[src]);
    launch(ch, 1'b0, 0);
    wait_done(ok);
    if (ok) begin
      check({req, " R3 result"}, int'(result), (raw < 20) ? 20 : raw);
      check({req, " R5 underrange"}, int'(underrange), (raw < 20) ? 1 : 0);
      check({req, " R3 frame count"}, frames, 14);
      check({req, " R4 zero or non-write frames"}, bad_frames, 0);
      check({req, " R9 busy low at done"}, int'(busy), 0);
    end
  endtask

  task automatic t_gng(string req, int ch, int lim, int exp_lim, int exp_pass);
    bit ok;
    launch(ch, 1'b1, lim);
    wait_done(ok);
    if (ok) begin
      check({req, " R6 pass"}, int'(pass), exp_pass);
      check({req, " R6 limit used"}, int'(result), exp_lim);
      check({req, " R6 frame count"}, frames, 2);
      check({req, " R4 bad frames"}, bad_frames, 0);
    end
  endtask

  task automatic t_reset();
    check("R10 busy", int'(busy), 0);
    check("R10 done", int'(done), 0);
    check("R10 result", int'(result), 0);
    check("R10 pass", int'(pass), 0);
    check("R10 underrange", int'(underrange), 0);
    check("R10 cs_n", int'(cs_n), 1);
    check("R10 sclk", int'(sclk), 0);
  endtask

  task automatic t_restart_ignored();
    bit ok;
    int seen;
    launch(0, 1'b0, 0);
    repeat (40) @(negedge clk);
    chan_sel = 2'd1; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    wait_done(ok);
    if (ok) begin
      check("R8 result from first request", int'(result), exp_raw(lvl[0]));
      check("R8 frame count", frames, 14);
    end
    seen = 0;
    for (int i = 0; i < 300; i++) begin
      @(negedge clk);
      if (done || busy) seen++;
    end
    check("R8 no second job", seen, 0);
    check("R9 result held", int'(result), exp_raw(lvl[0]));
  endtask

  initial begin
    n_chk = 0; n_fail = 0;
    start = 0; chan_sel = 0; mode_gng = 0; limit = 0;
    frames = 0; bad_frames = 0; dev_bits = 0;
    dev_dac = 7'd0; dev_in = 8'd0;
    lvl[0] = 85; lvl[1] = 200; lvl[2] = 65;
    dev_resp = dev_answer(7'd0); dev_out = dev_resp;
    rst_n = 1'b0;
    repeat (4) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    // R2 distinct channels, bit order 7/6/5
    t_full("R2 ch0 mid", 0, 0);
    t_full("R2 ch1 full scale", 1, 1);
    t_full("R2 ch2 just over msb", 2, 2);
    t_full("R7 select 3", 3, 2);
    lvl[0] = 21; t_full("R5 exactly floor", 0, 0);
    lvl[1] = 20; t_full("R5 one below floor", 1, 1);
    lvl[2] = 0;  t_full("R5 zero input", 2, 2);
    lvl[0] = 85; lvl[1] = 50; lvl[2] = 30;
    t_gng("R6 limit below level", 1, 49, 49, 1);
    t_gng("R6 limit equals level", 1, 50, 50, 0);
    t_gng("R6 low limit raised", 2, 5, 20, 1);
    t_gng("R7 gng select 3", 3, 31, 31, 0);
    t_restart_ignored();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=hung expected=finished");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule